// File: doc/BRIEF.md
# Auto-Stepping Memory Pointer Bank

This block holds a small set of memory pointers for a 16-bit signal processor. Each pointer has a 16-bit address and a 16-bit mode. A single setup register is used to program them. Software first writes an address word and then a mode word to it, and the block is then armed. The next access to any pointer port takes the programmed pair as that port's read pointer or its write pointer, depending on the direction of that access. Each port keeps a separate read pointer and write pointer.

Later accesses through a port decode the mode. The mode selects one of three targets: a word-wide ROM with a 4-bit bank extension, a data RAM, or an instruction RAM. The block then issues one registered request to that memory and moves the address by a step taken from the mode. Data-RAM writes can run in overwrite mode, where only the non-zero nibbles of the data are stored. The memories are plain synchronous arrays outside the block. Read data goes straight from the memories to the processor and does not pass through this block.

Top module: `mem_pointer_bank`

## Requirements
- R1: Setup has two phases. A setup write in the address phase stores the address and moves to the mode phase. A setup write in the mode phase stores the mode, arms the block and returns to the address phase. While the block is armed, the next port access copies {mode, address} into that port's read pointer (when `port_write`=0) or its write pointer (when `port_write`=1). It then disarms the block and issues no memory request.
- R2: The step comes from mode bits 13:11. Code 0 gives 0, codes 1 to 6 give 1, 2, 4, 8, 16 and 32, and code 7 gives 128. When mode bit 15 is 1 the step is subtracted instead of added.
- R3: A read whose mode satisfies (mode & 0xFFF0) == 0x0800 reads the ROM. The ROM address is {mode[3:0], address}, and the pointer address then increases by exactly 1.
- R4: A read with (mode & 0x47FF) == 0x0018 reads the data RAM. A write with (mode & 0x43FF) == 0x0018 writes the data RAM. Both use the 16-bit address and then apply the R2 step.
- R5: A write with (mode & 0xFBFF) == 0x4018 writes the data RAM and then moves the address by +31 if the address is odd, or by +1 if it is even.
- R6: On data-RAM writes under R4 or R5, mode bit 10 = 1 sets `dram_nib_en` bit i to 1 only when data nibble i is non-zero. Mode bit 10 = 0 gives 4'hF.
- R7: A write with (mode & 0x47FF) == 0x001C writes the instruction RAM at address bits 9:0 and then applies the R2 step. `iram_range_err` is set together with the write when the address lies outside 0x8000 to 0x83FF.
- R8: A setup read in the address phase returns the stored address and moves to the mode phase. A setup read in the mode phase returns the address rotated left by one nibble ({addr[11:0], addr[15:12]}), arms the block with the stored mode and returns to the address phase. `cfg_rdata` is updated one cycle after the read and holds its value otherwise.
- R9: An access whose mode matches no rule for its direction issues no memory request and raises `bad_mode` for one cycle.
- R10: Address arithmetic wraps modulo 2^16. Reset clears every pointer to zero (mode 0 is unhandled), disarms the block, returns setup to the address phase and clears `cfg_rdata`.
- R11: Every request strobe and `bad_mode` is registered and appears the cycle after the access. Read and write pointers are independent, including pointers on the same port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Setup register write |
| cfg_rd | input | 1 | Setup register read |
| cfg_wdata | input | 16 | Setup write data |
| cfg_rdata | output | 16 | Setup read data (registered) |
| port_valid | input | 1 | Pointer port access |
| port_write | input | 1 | Access direction, 1 = write |
| port_sel | input | SEL_W | Pointer port index |
| port_wdata | input | 16 | Write data for the access |
| rom_re | output | 1 | ROM read strobe |
| rom_addr | output | ROM_AW | ROM word address |
| dram_re | output | 1 | Data RAM read strobe |
| dram_we | output | 1 | Data RAM write strobe |
| dram_nib_en | output | 4 | Data RAM nibble write enables |
| dram_addr | output | 16 | Data RAM address |
| dram_wdata | output | 16 | Data RAM write data |
| iram_we | output | 1 | Instruction RAM write strobe |
| iram_addr | output | IRAM_AW | Instruction RAM address |
| iram_wdata | output | 16 | Instruction RAM write data |
| iram_range_err | output | 1 | Instruction RAM address outside its window |
| bad_mode | output | 1 | Access with an unhandled mode |

## Verification
The assertions assume that in each cycle there is at most one operation: a setup write, a setup read, or a port access. They also assume `port_sel` is below the port count and that the inputs are held low during reset. The stimulus drives only one of these strobes per cycle and draws port indices from the valid range. This holds in both the directed sequences and the random sequence. Within those limits the random sequence draws modes from every decode class and from fully random words. The random words reach the unhandled case and the instruction-RAM window edges.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  localparam int WORD_W = 16;
  localparam int NIB_N  = WORD_W / 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t mode;
    word_t addr;
  } ptr_t;

  typedef enum logic [2:0] {
    T_NONE, T_ROM, T_DRD, T_DWR, T_PAIR, T_IRAM
  } tgt_e;

  typedef enum logic {PH_ADDR, PH_MODE} phase_e;

  // signed power-of-two step from the mode word
  function automatic word_t step_of(word_t m);
    word_t mag;
    case (m[13:11])
      3'd0:    mag = '0;
      3'd7:    mag = word_t'(128);
      default: mag = word_t'(1) << (m[13:11] - 3'd1);
    endcase
    return m[15] ? (~mag + word_t'(1)) : mag;
  endfunction

  function automatic logic [NIB_N-1:0] nz_nibbles(word_t d);
    logic [NIB_N-1:0] r;
    for (int i = 0; i < NIB_N; i++) r[i] = |d[4*i +: 4];
    return r;
  endfunction
endpackage

// File: rtl/mpb_setup.sv
module mpb_setup
  import mpb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cfg_wr,
  input  logic  cfg_rd,
  input  word_t cfg_wdata,
  input  logic  consume,
  output logic  armed,
  output word_t addr_q,
  output word_t mode_q,
  output word_t rdata_q
);
  phase_e phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_ADDR;
      armed   <= 1'b0;
      addr_q  <= '0;
      mode_q  <= '0;
      rdata_q <= '0;
    end else if (cfg_wr) begin
      if (phase == PH_ADDR) begin
        addr_q <= cfg_wdata;
        phase  <= PH_MODE;
      end else begin
        mode_q <= cfg_wdata;
        armed  <= 1'b1;
        phase  <= PH_ADDR;
      end
    end else if (cfg_rd) begin
      if (phase == PH_ADDR) begin
        rdata_q <= addr_q;
        phase   <= PH_MODE;
      end else begin
        rdata_q <= {addr_q[WORD_W-5:0], addr_q[WORD_W-1:WORD_W-4]};
        armed   <= 1'b1;
        phase   <= PH_ADDR;
      end
    end else if (consume) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/mpb_slots.sv
module mpb_slots
  import mpb_pkg::*;
#(
  parameter int N_PORTS = 5,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             dir_wr,
  input  logic             load,
  input  ptr_t             load_ptr,
  input  logic             upd,
  input  word_t            upd_addr,
  output ptr_t             cur_ptr
);
  ptr_t slot_v [2][N_PORTS];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      ptr_t q;
      logic hit;
      assign hit = (sel == SEL_W'(p)) && (dir_wr == (d == 1));
      always_ff @(posedge clk) begin
        if (rst)             q <= '0;
        else if (load && hit) q <= load_ptr;
        else if (upd && hit)  q.addr <= upd_addr;
      end
      assign slot_v[d][p] = q;
    end
  end

  always_comb begin
    cur_ptr = '0;
    for (int d = 0; d < 2; d++)
      for (int p = 0; p < N_PORTS; p++)
        if ((sel == SEL_W'(p)) && (dir_wr == (d == 1))) cur_ptr = slot_v[d][p];
  end
endmodule

// File: rtl/mpb_decode.sv
module mpb_decode
  import mpb_pkg::*;
(
  input  ptr_t             ptr,
  input  logic             is_wr,
  input  word_t            wdata,
  output tgt_e             tgt,
  output word_t            nxt_addr,
  output logic [NIB_N-1:0] nib_en
);
  localparam word_t ROM_MASK  = 16'hFFF0, ROM_VAL  = 16'h0800;
  localparam word_t DRD_MASK  = 16'h47FF, DRD_VAL  = 16'h0018;
  localparam word_t DWR_MASK  = 16'h43FF, DWR_VAL  = 16'h0018;
  localparam word_t PAIR_MASK = 16'hFBFF, PAIR_VAL = 16'h4018;
  localparam word_t IRAM_MASK = 16'h47FF, IRAM_VAL = 16'h001C;

  word_t m, a, stp;

  always_comb begin
    m   = ptr.mode;
    a   = ptr.addr;
    stp = step_of(m);
    tgt = T_NONE;
    nxt_addr = a;
    if (!is_wr) begin
      if ((m & ROM_MASK) == ROM_VAL) begin
        tgt = T_ROM;
        nxt_addr = a + word_t'(1);
      end else if ((m & DRD_MASK) == DRD_VAL) begin
        tgt = T_DRD;
        nxt_addr = a + stp;
      end
    end else begin
      if ((m & DWR_MASK) == DWR_VAL) begin
        tgt = T_DWR;
        nxt_addr = a + stp;
      end else if ((m & PAIR_MASK) == PAIR_VAL) begin
        tgt = T_PAIR;
        nxt_addr = a + (a[0] ? word_t'(31) : word_t'(1));
      end else if ((m & IRAM_MASK) == IRAM_VAL) begin
        tgt = T_IRAM;
        nxt_addr = a + stp;
      end
    end
    nib_en = m[10] ? nz_nibbles(wdata) : '1;
  end
endmodule

// File: rtl/mem_pointer_bank.sv
module mem_pointer_bank
  import mpb_pkg::*;
#(
  parameter int          N_PORTS   = 5,
  parameter int          ROM_AW    = 20,
  parameter int          IRAM_AW   = 10,
  parameter logic [15:0] IRAM_BASE = 16'h8000,
  localparam int         SEL_W     = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [15:0]        cfg_wdata,
  output logic [15:0]        cfg_rdata,
  input  logic               port_valid,
  input  logic               port_write,
  input  logic [SEL_W-1:0]   port_sel,
  input  logic [15:0]        port_wdata,
  output logic               rom_re,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic               dram_re,
  output logic               dram_we,
  output logic [3:0]         dram_nib_en,
  output logic [15:0]        dram_addr,
  output logic [15:0]        dram_wdata,
  output logic               iram_we,
  output logic [IRAM_AW-1:0] iram_addr,
  output logic [15:0]        iram_wdata,
  output logic               iram_range_err,
  output logic               bad_mode
);
  localparam int BANK_W = ROM_AW - WORD_W;

  logic  armed, acc, load, use_ptr, upd, in_window;
  word_t set_addr, set_mode, nxt_addr;
  ptr_t  cur;
  tgt_e  tgt;
  logic [NIB_N-1:0] nib;

  assign acc     = port_valid && !cfg_wr && !cfg_rd && (port_sel < SEL_W'(N_PORTS));
  assign load    = acc && armed;
  assign use_ptr = acc && !armed;
  assign upd     = use_ptr && (tgt != T_NONE);
  assign in_window = (cur.addr[WORD_W-1:IRAM_AW] == IRAM_BASE[WORD_W-1:IRAM_AW]);

  mpb_setup u_setup (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata),
    .consume(load), .armed(armed), .addr_q(set_addr), .mode_q(set_mode),
    .rdata_q(cfg_rdata)
  );

  mpb_slots #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_slots (
    .clk(clk), .rst(rst), .sel(port_sel), .dir_wr(port_write),
    .load(load), .load_ptr('{mode: set_mode, addr: set_addr}),
    .upd(upd), .upd_addr(nxt_addr), .cur_ptr(cur)
  );

  mpb_decode u_dec (
    .ptr(cur), .is_wr(port_write), .wdata(port_wdata),
    .tgt(tgt), .nxt_addr(nxt_addr), .nib_en(nib)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_re         <= 1'b0;
      rom_addr       <= '0;
      dram_re        <= 1'b0;
      dram_we        <= 1'b0;
      dram_nib_en    <= '0;
      dram_addr      <= '0;
      dram_wdata     <= '0;
      iram_we        <= 1'b0;
      iram_addr      <= '0;
      iram_wdata     <= '0;
      iram_range_err <= 1'b0;
      bad_mode       <= 1'b0;
    end else begin
      rom_re         <= use_ptr && (tgt == T_ROM);
      dram_re        <= use_ptr && (tgt == T_DRD);
      dram_we        <= use_ptr && (tgt == T_DWR || tgt == T_PAIR);
      iram_we        <= use_ptr && (tgt == T_IRAM);
      iram_range_err <= use_ptr && (tgt == T_IRAM) && !in_window;
      bad_mode       <= use_ptr && (tgt == T_NONE);
      if (use_ptr && tgt == T_ROM)
        rom_addr <= {cur.mode[BANK_W-1:0], cur.addr};
      if (use_ptr && (tgt == T_DRD || tgt == T_DWR || tgt == T_PAIR))
        dram_addr <= cur.addr;
      if (use_ptr && (tgt == T_DWR || tgt == T_PAIR)) begin
        dram_wdata  <= port_wdata;
        dram_nib_en <= nib;
      end
      if (use_ptr && tgt == T_IRAM) begin
        iram_addr  <= cur.addr[IRAM_AW-1:0];
        iram_wdata <= port_wdata;
      end
    end
  end
endmodule

// File: rtl/mpb_chk.sv
module mpb_chk
  import mpb_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        cfg_wr,
  input logic        cfg_rd,
  input logic        port_valid,
  input logic        port_write,
  input logic        rom_re,
  input logic        dram_re,
  input logic        dram_we,
  input logic [3:0]  dram_nib_en,
  input logic [15:0] dram_wdata,
  input logic        iram_we,
  input logic        iram_range_err,
  input logic        bad_mode
);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_re, dram_re, dram_we, iram_we, bad_mode}));

  // R11
  strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (rom_re || dram_re || dram_we || iram_we || bad_mode)
      |-> $past(port_valid && !cfg_wr && !cfg_rd));

  // R11
  read_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (rom_re || dram_re) |-> !$past(port_write));

  // R11
  write_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (dram_we || iram_we) |-> $past(port_write));

  // R6
  nibble_mask_chk: assert property (@(posedge clk) disable iff (rst)
    dram_we |-> (dram_nib_en == 4'hF || dram_nib_en == nz_nibbles(dram_wdata)));

  // R7
  range_err_chk: assert property (@(posedge clk) disable iff (rst)
    iram_range_err |-> iram_we);
endmodule

bind mem_pointer_bank mpb_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .port_valid(port_valid), .port_write(port_write),
  .rom_re(rom_re), .dram_re(dram_re), .dram_we(dram_we),
  .dram_nib_en(dram_nib_en), .dram_wdata(dram_wdata),
  .iram_we(iram_we), .iram_range_err(iram_range_err), .bad_mode(bad_mode)
);

// File: tb/mem_pointer_bank_test.sv
module mem_pointer_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 5;
  localparam int SW = $clog2(N);

  logic clk = 0, rst = 1;
  logic cfg_wr = 0, cfg_rd = 0, port_valid = 0, port_write = 0;
  logic [15:0] cfg_wdata = 0, port_wdata = 0;
  logic [SW-1:0] port_sel = 0;
  logic [15:0] cfg_rdata, dram_addr, dram_wdata, iram_wdata;
  logic [19:0] rom_addr;
  logic [9:0]  iram_addr;
  logic [3:0]  dram_nib_en;
  logic rom_re, dram_re, dram_we, iram_we, iram_range_err, bad_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_pointer_bank uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .port_valid(port_valid), .port_write(port_write),
    .port_sel(port_sel), .port_wdata(port_wdata), .rom_re(rom_re), .rom_addr(rom_addr),
    .dram_re(dram_re), .dram_we(dram_we), .dram_nib_en(dram_nib_en),
    .dram_addr(dram_addr), .dram_wdata(dram_wdata), .iram_we(iram_we),
    .iram_addr(iram_addr), .iram_wdata(iram_wdata),
    .iram_range_err(iram_range_err), .bad_mode(bad_mode)
  );

  int n_cmp = 0, n_bad = 0;
  bit started = 0, done = 0;
  string scen = "R10", m_tag = "R10";

  // behavioural reference model
  logic [31:0] m_slot [2][N];
  bit m_phase, m_armed;
  logic [15:0] m_addr, m_mode;
  logic e_rom_re, e_dram_re, e_dram_we, e_iram_we, e_err, e_bad;
  logic [19:0] e_rom_addr;
  logic [15:0] e_dram_addr, e_dram_wdata, e_iram_wdata, e_cfg;
  logic [9:0]  e_iram_addr;
  logic [3:0]  e_nib;

  function automatic logic [15:0] model_step(logic [15:0] md);
    logic [15:0] s;
    int c = int'(md[13:11]);
    if (c == 0) s = 16'd0;
    else if (c == 7) s = 16'd128;
    else s = 16'd1 << (c - 1);
    if (md[15]) s = ~s + 16'd1;
    return s;
  endfunction

  always @(posedge clk) begin : model
    logic [15:0] md, ad;
    int d, p;
    e_rom_re = 0; e_dram_re = 0; e_dram_we = 0; e_iram_we = 0; e_err = 0; e_bad = 0;
    m_tag = scen;
    if (rst) begin
      started = 1;
      for (int i = 0; i < 2; i++) for (int j = 0; j < N; j++) m_slot[i][j] = 0;
      m_phase = 0; m_armed = 0; m_addr = 0; m_mode = 0; e_cfg = 0;
    end else if (cfg_wr) begin
      if (!m_phase) begin m_addr = cfg_wdata; m_phase = 1; end
      else begin m_mode = cfg_wdata; m_armed = 1; m_phase = 0; end
    end else if (cfg_rd) begin
      if (!m_phase) begin e_cfg = m_addr; m_phase = 1; end
      else begin e_cfg = {m_addr[11:0], m_addr[15:12]}; m_armed = 1; m_phase = 0; end
    end else if (port_valid && int'(port_sel) < N) begin
      d = port_write ? 1 : 0;
      p = int'(port_sel);
      if (m_armed) begin
        m_slot[d][p] = {m_mode, m_addr};
        m_armed = 0;
      end else begin
        md = m_slot[d][p][31:16];
        ad = m_slot[d][p][15:0];
        if (d == 0 && (md & 16'hFFF0) == 16'h0800) begin
          e_rom_re = 1; e_rom_addr = {md[3:0], ad}; ad = ad + 16'd1;
        end else if (d == 0 && (md & 16'h47FF) == 16'h0018) begin
          e_dram_re = 1; e_dram_addr = ad; ad = ad + model_step(md);
        end else if (d == 1 && ((md & 16'h43FF) == 16'h0018 || (md & 16'hFBFF) == 16'h4018)) begin
          e_dram_we = 1; e_dram_addr = ad; e_dram_wdata = port_wdata;
          e_nib = 4'hF;
          if (md[10])
            for (int k = 0; k < 4; k++) e_nib[k] = (port_wdata[4*k +: 4] != 0);
          if (md[14]) ad = ad + (ad[0] ? 16'd31 : 16'd1);
          else ad = ad + model_step(md);
        end else if (d == 1 && (md & 16'h47FF) == 16'h001C) begin
          e_iram_we = 1; e_iram_addr = ad[9:0]; e_iram_wdata = port_wdata;
          e_err = (ad < 16'h8000) || (ad > 16'h83FF);
          ad = ad + model_step(md);
        end else begin
          e_bad = 1;
        end
        m_slot[d][p][15:0] = ad;
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] at %0t: actual %h expected %h", what, m_tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R8 cfg_rdata", cfg_rdata, e_cfg);
      chk("R3 rom_re", rom_re, e_rom_re);
      chk("R4 dram_re", dram_re, e_dram_re);
      chk("R4 dram_we", dram_we, e_dram_we);
      chk("R7 iram_we", iram_we, e_iram_we);
      chk("R7 iram_range_err", iram_range_err, e_err);
      chk("R9 bad_mode", bad_mode, e_bad);
      if (e_rom_re) chk("R3 rom_addr", rom_addr, e_rom_addr);
      if (e_dram_re || e_dram_we) chk("R2 dram_addr", dram_addr, e_dram_addr);
      if (e_dram_we) begin
        chk("R4 dram_wdata", dram_wdata, e_dram_wdata);
        chk("R6 dram_nib_en", dram_nib_en, e_nib);
      end
      if (e_iram_we) begin
        chk("R7 iram_addr", iram_addr, e_iram_addr);
        chk("R7 iram_wdata", iram_wdata, e_iram_wdata);
      end
    end
  end

  task automatic cyc(bit w, bit r, bit v, bit pw, int s, logic [15:0] dat);
    @(negedge clk);
    cfg_wr = w; cfg_rd = r; port_valid = v; port_write = pw;
    port_sel = SW'(s); cfg_wdata = dat; port_wdata = dat;
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 16'h0); endtask

  task automatic acc(int p, bit wr, logic [15:0] dat); cyc(0, 0, 1, wr, p, dat); endtask

  // R1: address, mode, then the arming access
  task automatic prog(int p, bit wr, logic [15:0] a, logic [15:0] m);
    cyc(1, 0, 0, 0, 0, a);
    cyc(1, 0, 0, 0, 0, m);
    acc(p, wr, 16'h0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin : stim
    logic [15:0] m;
    repeat (3) @(negedge clk);
    rst = 0;
    scen = "R10";
    idle();
    acc(0, 0, 16'h0);
    acc(1, 1, 16'h5);
    idle();

    scen = "R1";
    prog(1, 0, 16'h1234, 16'h0803);
    scen = "R3";
    repeat (3) acc(1, 0, 16'h0);

    scen = "R10";
    prog(2, 0, 16'hFFFF, 16'h0805);
    repeat (2) acc(2, 0, 16'h0);

    scen = "R2";
    for (int c = 0; c < 8; c++)
      for (int dr = 0; dr < 2; dr++) begin
        prog(0, 0, 16'h0100, 16'((dr << 15) | (c << 11) | 16'h0018));
        repeat (3) acc(0, 0, 16'h0);
      end

    scen = "R4";
    prog(3, 1, 16'h0040, 16'h0818);
    acc(3, 1, 16'hA5C3); acc(3, 1, 16'h0000); acc(3, 1, 16'h1111);

    scen = "R6";
    prog(3, 1, 16'h0200, 16'h0C18);
    acc(3, 1, 16'h1020); acc(3, 1, 16'h0000); acc(3, 1, 16'hF00F);

    scen = "R5";
    prog(4, 1, 16'h0010, 16'h4018);
    for (int i = 0; i < 5; i++) acc(4, 1, 16'(i + 1));
    prog(4, 1, 16'hFFE1, 16'h4418);
    repeat (3) acc(4, 1, 16'h0300);

    scen = "R7";
    prog(0, 1, 16'h83FE, 16'h081C);
    repeat (3) acc(0, 1, 16'hBEEF);
    prog(0, 1, 16'h7FFF, 16'h001C);
    repeat (2) acc(0, 1, 16'h1234);

    scen = "R8";
    cyc(1, 0, 0, 0, 0, 16'hABCD);
    cyc(0, 1, 0, 0, 0, 16'h0);
    acc(2, 1, 16'h0);
    acc(2, 1, 16'h7777);
    cyc(0, 1, 0, 0, 0, 16'h0);
    cyc(0, 1, 0, 0, 0, 16'h0);
    acc(3, 0, 16'h0);
    idle();

    scen = "R9";
    prog(1, 0, 16'h0000, 16'h0418);
    acc(1, 0, 16'h0);
    prog(1, 1, 16'h0000, 16'h0800);
    acc(1, 1, 16'h0);
    idle();

    scen = "R11";
    prog(2, 0, 16'h0500, 16'h0801);
    prog(2, 1, 16'h0600, 16'h0818);
    for (int i = 0; i < 3; i++) begin
      acc(2, 0, 16'h0);
      acc(2, 1, 16'(16'h0A00 + i));
    end

    scen = "R4";
    for (int it = 0; it < 600; it++) begin
      case ($urandom % 6)
        0: m = 16'h0800 | 16'($urandom % 16);
        1: m = 16'h0018 | 16'($urandom & 32'h8C00) | 16'(($urandom % 8) << 11);
        2: m = 16'h4018 | 16'($urandom & 32'h0400);
        3: m = 16'h001C | 16'($urandom & 32'h8000) | 16'(($urandom % 8) << 11);
        4: m = 16'($urandom);
        default: m = 16'h0018 | 16'(($urandom % 8) << 11);
      endcase
      prog(int'($urandom % N), bit'($urandom % 2),
           ($urandom % 2) ? 16'(16'h8000 + ($urandom % 16'h0480)) : 16'($urandom), m);
      for (int k = 0; k < 1 + int'($urandom % 6); k++) begin
        if ($urandom % 10 == 0) cyc(0, 1, 0, 0, 0, 16'h0);
        else acc(int'($urandom % N), bit'($urandom % 2), 16'($urandom));
      end
    end
    repeat (3) idle();
    finish_run();
  end
endmodule